// File: doc/BRIEF.md
# Bit-Serial Unsigned Adder

This block adds two unsigned operands of `W` bits by working through them one bit pair per clock cycle, least significant pair first. A single-cycle load strobe captures both operands in parallel into right-shifting registers and clears the carry logic. Each following cycle presents the low bit of each operand register to a small adder state machine. Each sum bit the machine produces enters a result register at its top end, so after the last capture the result register holds the full sum in normal bit order.

The adder core is a four-state machine whose output is taken from its state alone. The state records both the running carry and the sum bit being presented. This makes the sum stream one cycle late compared with a machine whose output depends on its inputs. The control adds one extra capture cycle to absorb that delay. A parameter instead selects a two-state core that produces the sum bit combinationally, which finishes one cycle sooner. In both variants, `done_o` pulses once when the result is complete. The sum and the carry-out then hold until the next load.

Top module: `bsa_top`

## Requirements
- R1: When `done_o` is high, `sum_o` equals (A + B) mod 2^W, where A and B are the operands presented with the most recent load.
- R2: When `done_o` is high, `cout_o` equals bit W of the (W+1)-bit sum A + B.
- R3: `done_o` is high for exactly one cycle per operation. With `MOORE_CORE`=1 it is first seen W+1 cycles after the clock edge that accepted the load. With `MOORE_CORE`=0 this is W cycles.
- R4: From the cycle in which `done_o` is high until the next load is accepted, `sum_o` and `cout_o` keep their values.
- R5: While `rst_n` is low, `done_o`, `cout_o` and `sum_o` are all zero.
- R6: A load accepted while an operation is still running abandons that operation. No `done_o` pulse appears for the abandoned operation. The next result and its timing (R1 to R3) are measured from the new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load_i | input | 1 | Start strobe: capture operands and begin a new addition |
| opa_i | input | W | First operand, sampled when `load_i` is high |
| opb_i | input | W | Second operand, sampled when `load_i` is high |
| sum_o | output | W | Result register, valid from `done_o` until the next load |
| cout_o | output | 1 | Carry out of the most significant bit, valid with `sum_o` |
| done_o | output | 1 | One-cycle pulse marking a complete result |

## Verification
A carry state that is wrong or is disturbed in the extra Moore cycle corrupts the upper sum bits or `cout_o`. This shows in the very `done_o` cycle of the affected operation, so an exhaustive sweep of both operands at a small width finds every such fault. A counter or phase error moves the `done_o` pulse by a cycle, or shifts the result by one position (a lost low bit and a stale top bit). The first operation after reset exposes this. A missing hold shows up in the cycles right after `done_o`, where the outputs are compared again.

// File: rtl/bsa_pkg.sv
`timescale 1ns/1ps
package bsa_pkg;

  // Four-state core: bit 1 carries the running carry, bit 0 the sum bit on show.
  typedef enum logic [1:0] {
    MS_C0_S0 = 2'b00,
    MS_C0_S1 = 2'b01,
    MS_C1_S0 = 2'b10,
    MS_C1_S1 = 2'b11
  } moore_st_e;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  function automatic logic par3(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

endpackage

// File: rtl/bsa_shreg.sv
`timescale 1ns/1ps
// Right-shifting register: parallel load has priority, serial bit enters at the MSB.
module bsa_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         sh_en_i,
  input  logic         ser_i,
  output logic         lsb_o,
  output logic [W-1:0] par_o
);

  logic [W-1:0] data_q;
  logic [W-1:0] data_d;
  logic         data_en;

  always_comb begin
    data_en = ld_i | sh_en_i;
    if (ld_i) begin
      data_d = ld_val_i;
    end else if (W > 1) begin
      data_d = {ser_i, data_q[W-1:1]};
    end else begin
      data_d = {W{ser_i}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  assign lsb_o = data_q[0];
  assign par_o = data_q;

endmodule

// File: rtl/bsa_core.sv
`timescale 1ns/1ps
// Serial adder state machine; MOORE_CORE picks registered or combinational sum bit.
module bsa_core
  import bsa_pkg::*;
#(
  parameter bit MOORE_CORE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  input  logic a_i,
  input  logic b_i,
  output logic sum_bit_o,
  output logic carry_o
);

  generate
    if (MOORE_CORE) begin : g_moore
      moore_st_e st_q;
      moore_st_e st_d;

      always_comb begin
        st_d = st_q;
        if (clr_i) begin
          st_d = MS_C0_S0;
        end else if (en_i) begin
          st_d = moore_st_e'({maj3(a_i, b_i, st_q[1]), par3(a_i, b_i, st_q[1])});
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_q <= MS_C0_S0;
        end else if (clr_i | en_i) begin
          st_q <= st_d;
        end
      end

      assign sum_bit_o = st_q[0];
      assign carry_o   = st_q[1];
    end else begin : g_mealy
      logic cy_q;
      logic cy_d;

      always_comb begin
        cy_d = cy_q;
        if (clr_i) begin
          cy_d = 1'b0;
        end else if (en_i) begin
          cy_d = maj3(a_i, b_i, cy_q);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cy_q <= 1'b0;
        end else if (clr_i | en_i) begin
          cy_q <= cy_d;
        end
      end

      assign sum_bit_o = par3(a_i, b_i, cy_q);
      assign carry_o   = cy_q;
    end
  endgenerate

endmodule

// File: rtl/bsa_ctrl.sv
`timescale 1ns/1ps
// Sequencer: counts bit cycles plus LAT extra capture cycles, then pulses done.
module bsa_ctrl #(
  parameter int W   = 8,
  parameter int LAT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic fsm_en_o,
  output logic sum_en_o,
  output logic done_o
);

  localparam int TOTAL = W + LAT;
  localparam int CW    = (TOTAL > 1) ? $clog2(TOTAL) : 1;
  localparam logic [CW-1:0] LAST  = CW'(TOTAL - 1);
  localparam logic [CW-1:0] NBITS = CW'(W - 1);

  logic          run_q,  run_d;
  logic [CW-1:0] cnt_q,  cnt_d;
  logic          done_q, done_d;
  logic          step;

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    step   = run_q & ~load_i;
    if (load_i) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (run_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
      if (load_i | step) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign fsm_en_o = step & (cnt_q <= NBITS);

  generate
    if (LAT == 0) begin : g_nolat
      assign sum_en_o = step;
    end else begin : g_lat
      assign sum_en_o = step & (cnt_q >= CW'(LAT));
    end
  endgenerate

  assign done_o = done_q;

endmodule

// File: rtl/bsa_top.sv
`timescale 1ns/1ps
module bsa_top #(
  parameter int W          = 8,
  parameter bit MOORE_CORE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         done_o
);

  localparam int LAT = MOORE_CORE ? 1 : 0;

  logic fsm_en, sum_en;
  logic a_bit, b_bit, s_bit;
  logic [W-1:0] a_par, b_par;

  bsa_ctrl #(.W(W), .LAT(LAT)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_i),
    .fsm_en_o (fsm_en),
    .sum_en_o (sum_en),
    .done_o   (done_o)
  );

  bsa_shreg #(.W(W)) u_opa (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_i     (load_i),
    .ld_val_i (opa_i),
    .sh_en_i  (fsm_en),
    .ser_i    (1'b0),
    .lsb_o    (a_bit),
    .par_o    (a_par)
  );

  bsa_shreg #(.W(W)) u_opb (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_i     (load_i),
    .ld_val_i (opb_i),
    .sh_en_i  (fsm_en),
    .ser_i    (1'b0),
    .lsb_o    (b_bit),
    .par_o    (b_par)
  );

  bsa_core #(.MOORE_CORE(MOORE_CORE)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (load_i),
    .en_i      (fsm_en),
    .a_i       (a_bit),
    .b_i       (b_bit),
    .sum_bit_o (s_bit),
    .carry_o   (cout_o)
  );

  logic sum_lsb_unused;

  bsa_shreg #(.W(W)) u_sum (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_i     (load_i),
    .ld_val_i ({W{1'b0}}),
    .sh_en_i  (sum_en),
    .ser_i    (s_bit),
    .lsb_o    (sum_lsb_unused),
    .par_o    (sum_o)
  );

  logic unused_par;
  assign unused_par = ^{a_par, b_par, sum_lsb_unused};

endmodule

// File: rtl/bsa_chk.sv
`timescale 1ns/1ps
module bsa_chk #(
  parameter int W          = 8,
  parameter bit MOORE_CORE = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_i,
  input logic [W-1:0] opa_i,
  input logic [W-1:0] opb_i,
  input logic [W-1:0] sum_o,
  input logic         cout_o,
  input logic         done_o
);

  localparam int TOTAL = W + (MOORE_CORE ? 1 : 0);
  localparam int SW    = $clog2(TOTAL + 2);
  localparam logic [SW-1:0] SAT  = SW'(TOTAL + 1);
  localparam logic [SW-1:0] TGT  = SW'(TOTAL);

  logic [W-1:0]  cap_a, cap_b;
  logic [SW-1:0] since_q;
  logic [W:0]    ref_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a   <= '0;
      cap_b   <= '0;
      since_q <= SAT;
    end else if (load_i) begin
      cap_a   <= opa_i;
      cap_b   <= opb_i;
      since_q <= '0;
    end else if (since_q != SAT) begin
      since_q <= since_q + 1'b1;
    end
  end

  assign ref_sum = {1'b0, cap_a} + {1'b0, cap_b};

  AST_SUM_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> sum_o == ref_sum[W-1:0]); // R1
  AST_CARRY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> cout_o == ref_sum[W]); // R2
  AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> since_q == TGT); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !load_i |=> !done_o); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !load_i |=> $stable(sum_o) && $stable(cout_o)); // R4
  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (TOTAL > 1) && load_i |=> !done_o); // R6

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (!done_o && !cout_o && sum_o == '0); // R5
    end
  end

endmodule

bind bsa_top bsa_chk #(.W(W), .MOORE_CORE(MOORE_CORE)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .load_i (load_i),
  .opa_i  (opa_i),
  .opb_i  (opb_i),
  .sum_o  (sum_o),
  .cout_o (cout_o),
  .done_o (done_o)
);

// File: tb/bsa_top_tb.sv
`timescale 1ns/1ps
module bsa_top_tb;

  localparam int W = 4;

  logic         clk;
  logic         rst_n;
  logic         load;
  logic [W-1:0] opa, opb;
  logic [W-1:0] sum_mo, sum_ml;
  logic         cout_mo, cout_ml, done_mo, done_ml;

  int checks = 0;
  int errors = 0;

  bsa_top #(.W(W), .MOORE_CORE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load), .opa_i(opa), .opb_i(opb),
    .sum_o(sum_mo), .cout_o(cout_mo), .done_o(done_mo)
  );

  bsa_top #(.W(W), .MOORE_CORE(1'b0)) u_dut_ml (
    .clk(clk), .rst_n(rst_n), .load_i(load), .opa_i(opa), .opb_i(opb),
    .sum_o(sum_ml), .cout_o(cout_ml), .done_o(done_ml)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Load a/b, then watch both variants for W+3 cycles after the load edge.
  task automatic do_add(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] exp;
    exp = {1'b0, a} + {1'b0, b};
    @(negedge clk);
    load = 1'b1; opa = a; opb = b;
    @(negedge clk);
    load = 1'b0; opa = ~a; opb = ~b;
    for (int k = 1; k <= W + 3; k++) begin
      @(negedge clk);
      chk(done_mo == (k == W + 1), "R3 moore done", done_mo, int'(k == W + 1));
      chk(done_ml == (k == W),     "R3 mealy done", done_ml, int'(k == W));
      if (k == W + 1) begin
        chk(sum_mo == exp[W-1:0], "R1 moore sum", sum_mo, exp[W-1:0]);
        chk(cout_mo == exp[W],    "R2 moore cout", cout_mo, exp[W]);
      end else if (k > W + 1) begin
        chk(sum_mo == exp[W-1:0] && cout_mo == exp[W], "R4 moore hold",
            {cout_mo, sum_mo}, exp);
      end
      if (k == W) begin
        chk(sum_ml == exp[W-1:0], "R1 mealy sum", sum_ml, exp[W-1:0]);
        chk(cout_ml == exp[W],    "R2 mealy cout", cout_ml, exp[W]);
      end else if (k > W) begin
        chk(sum_ml == exp[W-1:0] && cout_ml == exp[W], "R4 mealy hold",
            {cout_ml, sum_ml}, exp);
      end
    end
  endtask

  initial begin
    rst_n = 1'b0;
    load  = 1'b0;
    opa   = '0;
    opb   = '0;
    repeat (3) @(negedge clk);
    // R5: reset state
    chk(!done_mo && !cout_mo && sum_mo == '0, "R5 moore reset", {done_mo, cout_mo, sum_mo}, 0);
    chk(!done_ml && !cout_ml && sum_ml == '0, "R5 mealy reset", {done_ml, cout_ml, sum_ml}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Corner operands first: zeros, ones, alternating.
    do_add('0, '0);
    do_add('1, '1);
    do_add(4'b1010, 4'b0101);
    do_add(4'b0101, 4'b0101);
    do_add('1, 4'b0001);

    // Exhaustive sweep of both operands (R1, R2, R3, R4).
    for (int ia = 0; ia < (1 << W); ia++) begin
      for (int ib = 0; ib < (1 << W); ib++) begin
        do_add(W'(ia), W'(ib));
      end
    end

    // R6: restart during a running addition.
    @(negedge clk);
    load = 1'b1; opa = '1; opb = '1;
    @(negedge clk);
    load = 1'b0;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(!done_mo && !done_ml, "R6 no done before restart", {done_mo, done_ml}, 0);
    end
    do_add(4'b0011, 4'b0110);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule